// File: doc/BRIEF.md
# Password-Gated Paged Register Write Controller

This block sits behind a byte-level serial bus front end. The front end reports five kinds of bus events as one-cycle strobes: start, repeated start, stop, a device-address byte, and a data byte from the host. It also reports a request for the next read byte. The block owns a 48-byte register space and an address pointer. Write bursts are held in a one-row (8-byte) buffer, and the buffered bytes reach the registers only when a stop arrives. After each commit the block reports busy for a fixed number of cycles. During that time the front end sees no acknowledge for a device-address byte.

Most locations can be written only while a 4-byte entry area matches a 4-byte stored password. Both password areas are all-ones after reset, so the block starts unlocked. While the filtered event input is high, incoming data bytes are refused and reads still work. Reads of the six counter locations come from one of two sources, chosen when the start is seen:
- a snapshot of the live working counters, if the event input is high;
- the stored copy, if it is low.

Top module: `pwgate_regwr`

## Requirements
- R1: After reset the pointer is 00h, the entry area (02h–05h) and the stored password (1Ah–1Dh) all hold FFh, so the block is unlocked. Every other stored byte is 00h and busy is low.
- R2: A device-address byte following a start is acknowledged only for D6h (write) or D7h (read). Any other value is not acknowledged, and every later byte is refused until the next start or repeated start.
- R3: In a write, the first data byte loads the pointer and the following bytes are buffered. The pointer's low 3 bits advance and wrap inside the 8-byte row, so a burst at 2Eh fills 2Eh, 2Fh and then 28h.
- R4: Buffered bytes change the registers only on a stop. A repeated start discards them.
- R5: A stop that commits at least one buffered byte raises busy for BUSY_CYCLES cycles. While busy, a device-address byte is not acknowledged.
- R6: Reads of 02h–05h and 1Ah–1Dh return 00h.
- R7: 00h–05h are always writable. 08h–0Dh, 10h–16h and 20h–2Fh are written only when bytes 02h..05h equal bytes 1Ah..1Dh position by position; otherwise the write is dropped.
- R8: 1Ah–1Dh change only when all four are buffered in the same burst while unlocked. A partial write leaves the stored password as it was.
- R9: Reserved locations (06h, 07h, 0Eh, 0Fh, 17h–19h, 1Eh, 1Fh, 30h and above) read FFh. Each read byte advances the pointer by one, across rows.
- R10: While eventHigh is 1, data bytes after the pointer byte are not acknowledged and never reach the registers. Reads proceed normally.
- R11: For 08h–0Dh, if eventHigh was 1 at the last start or repeated start, reads return the snapshot of liveCounters taken then (byte k of location 08h+k is liveCounters[8k+7:8k]). Otherwise reads return the stored bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startStb | input | 1 | Start condition seen |
| rstartStb | input | 1 | Repeated start seen |
| stopStb | input | 1 | Stop condition seen |
| addrStb | input | 1 | byteIn is a device-address byte |
| dataStb | input | 1 | byteIn is a host data byte |
| rdReq | input | 1 | Host needs the next read byte |
| byteIn | input | 8 | Received byte |
| eventHigh | input | 1 | Filtered event level |
| liveCounters | input | 48 | Working counter bytes for locations 08h–0Dh |
| ackOut | output | 1 | Acknowledge for the last address or data byte |
| rdData | output | 8 | Read byte, valid the cycle after rdReq |
| busy | output | 1 | Persistent write in progress |

## Verification
The hardest state to reach is the locked state. It exists only after a full four-byte stored-password burst has been committed while unlocked. The partial-burst case must be shown to leave the lock untouched, even though the password bytes always read back as zeros. The stimulus therefore infers the lock state from its effect: it attempts a guarded write and reads the location back, first after a partial password write, then after a full one, and again after the matching entry bytes are written. The counter snapshot is reached by holding eventHigh across the start of a read transaction and comparing the result with a read made with eventHigh low.

// File: rtl/pwgate_pkg.sv
package pwgate_pkg;
  localparam int REG_BYTES = 48;
  localparam int ROW_BITS = 3;
  localparam int ROW_SLOTS = 1 << ROW_BITS;
  localparam logic [7:0] DEV_WR = 8'hD6;
  localparam logic [7:0] DEV_RD = 8'hD7;

  typedef struct packed {
    logic loadPtr;
    logic bufWrite;
    logic commit;
    logic discard;
    logic advanceRead;
    logic takeSnap;
  } ctlStrb_t;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_PTR, S_WDATA, S_READ, S_SKIP} ctlState_t;

  function automatic logic isPwEntry(input logic [7:0] a);
    return a >= 8'h02 && a <= 8'h05;
  endfunction

  function automatic logic isPwStore(input logic [7:0] a);
    return a >= 8'h1A && a <= 8'h1D;
  endfunction

  function automatic logic isCounter(input logic [7:0] a);
    return a >= 8'h08 && a <= 8'h0D;
  endfunction

  function automatic logic isGuarded(input logic [7:0] a);
    return isCounter(a) || (a >= 8'h10 && a <= 8'h16) || (a >= 8'h20 && a <= 8'h2F);
  endfunction

  function automatic logic isReserved(input logic [7:0] a);
    return a >= 8'h30 || a == 8'h06 || a == 8'h07 || a == 8'h0E || a == 8'h0F ||
           (a >= 8'h17 && a <= 8'h19) || a == 8'h1E || a == 8'h1F;
  endfunction

  function automatic logic [7:0] resetVal(input int i);
    return ((i >= 2 && i <= 5) || (i >= 26 && i <= 29)) ? 8'hFF : 8'h00;
  endfunction
endpackage

// File: rtl/pwgate_ctrl.sv
module pwgate_ctrl
  import pwgate_pkg::*;
#(
  parameter int BUSY_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startStb,
  input  logic       rstartStb,
  input  logic       stopStb,
  input  logic       addrStb,
  input  logic       dataStb,
  input  logic       rdReq,
  input  logic [7:0] byteIn,
  input  logic       eventHigh,
  input  logic       pending,
  output ctlStrb_t   strb,
  output logic       ackOut,
  output logic       busy
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);

  ctlState_t state, stateNxt;
  logic ackNxt;
  logic [CW-1:0] busyCnt;

  always_comb begin
    strb = '0;
    stateNxt = state;
    ackNxt = ackOut;
    if (startStb || rstartStb) begin
      stateNxt = S_ADDR;
      strb.discard = 1'b1;
      strb.takeSnap = 1'b1;
    end else if (stopStb) begin
      strb.commit = (state == S_WDATA) && pending;
      stateNxt = S_IDLE;
    end else if (addrStb) begin
      ackNxt = 1'b0;
      stateNxt = S_SKIP;
      if (state == S_ADDR && !busy) begin
        if (byteIn == DEV_WR) begin
          ackNxt = 1'b1;
          stateNxt = S_PTR;
        end else if (byteIn == DEV_RD) begin
          ackNxt = 1'b1;
          stateNxt = S_READ;
        end
      end
    end else if (dataStb) begin
      ackNxt = 1'b0;
      if (state == S_PTR) begin
        strb.loadPtr = 1'b1;
        ackNxt = 1'b1;
        stateNxt = S_WDATA;
      end else if (state == S_WDATA && !eventHigh) begin
        strb.bufWrite = 1'b1;
        ackNxt = 1'b1;
      end
    end else if (rdReq && state == S_READ) begin
      strb.advanceRead = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      ackOut <= 1'b0;
      busyCnt <= '0;
    end else begin
      state <= stateNxt;
      ackOut <= ackNxt;
      if (strb.commit) busyCnt <= CW'(BUSY_CYCLES);
      else if (busyCnt != '0) busyCnt <= busyCnt - 1'b1;
    end
  end

  assign busy = (busyCnt != '0);
endmodule

// File: rtl/pwgate_dpath.sv
module pwgate_dpath
  import pwgate_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  ctlStrb_t    strb,
  input  logic [7:0]  byteIn,
  input  logic        eventHigh,
  input  logic [47:0] liveCounters,
  output logic [7:0]  rdData,
  output logic        pending
);
  logic [7:0] regs [REG_BYTES];
  logic [7:0] bufData [ROW_SLOTS];
  logic [ROW_SLOTS-1:0] bufValid;
  logic [ROW_SLOTS-1:0] slotEn;
  logic [7:0] slotLoc [ROW_SLOTS];
  logic [7:0] ptr;
  logic [47:0] snap;
  logic snapSel;
  logic unlocked, fullPw;
  logic [7:0] rdMux;
  logic [2:0] cIdx;

  assign unlocked = {regs[5], regs[4], regs[3], regs[2]} == {regs[29], regs[28], regs[27], regs[26]};
  assign fullPw = (ptr[7:ROW_BITS] == 5'd3) && (&bufValid[5:2]);
  assign pending = |bufValid;

  for (genvar g = 0; g < ROW_SLOTS; g++) begin : g_slot
    assign slotLoc[g] = {ptr[7:ROW_BITS], ROW_BITS'(g)};
    assign slotEn[g] = bufValid[g] &&
      (isPwEntry(slotLoc[g]) || slotLoc[g] <= 8'h01 ||
       (unlocked && (isGuarded(slotLoc[g]) || (isPwStore(slotLoc[g]) && fullPw))));
  end

  assign cIdx = 3'(ptr - 8'h08);

  always_comb begin
    if (isReserved(ptr)) rdMux = 8'hFF;
    else if (isPwEntry(ptr) || isPwStore(ptr)) rdMux = 8'h00;
    else if (isCounter(ptr) && snapSel) rdMux = snap[{cIdx, 3'b000} +: 8];
    else rdMux = regs[ptr[5:0]];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < REG_BYTES; i++) regs[i] <= resetVal(i);
      for (int i = 0; i < ROW_SLOTS; i++) bufData[i] <= '0;
      bufValid <= '0;
      ptr <= '0;
      snap <= '0;
      snapSel <= 1'b0;
      rdData <= '0;
    end else begin
      if (strb.commit) begin
        for (int i = 0; i < ROW_SLOTS; i++)
          if (slotEn[i]) regs[slotLoc[i][5:0]] <= bufData[i];
        bufValid <= '0;
      end else if (strb.discard) begin
        bufValid <= '0;
      end else if (strb.loadPtr) begin
        ptr <= byteIn;
        bufValid <= '0;
      end else if (strb.bufWrite) begin
        bufData[ptr[ROW_BITS-1:0]] <= byteIn;
        bufValid[ptr[ROW_BITS-1:0]] <= 1'b1;
        ptr[ROW_BITS-1:0] <= ptr[ROW_BITS-1:0] + 1'b1;
      end else if (strb.advanceRead) begin
        rdData <= rdMux;
        ptr <= ptr + 1'b1;
      end
      if (strb.takeSnap) begin
        snapSel <= eventHigh;
        if (eventHigh) snap <= liveCounters;
      end
    end
  end
endmodule

// File: rtl/pwgate_regwr.sv
module pwgate_regwr
  import pwgate_pkg::*;
#(
  parameter int BUSY_CYCLES = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startStb,
  input  logic        rstartStb,
  input  logic        stopStb,
  input  logic        addrStb,
  input  logic        dataStb,
  input  logic        rdReq,
  input  logic [7:0]  byteIn,
  input  logic        eventHigh,
  input  logic [47:0] liveCounters,
  output logic        ackOut,
  output logic [7:0]  rdData,
  output logic        busy
);
  ctlStrb_t strb;
  logic pending;

  pwgate_ctrl #(.BUSY_CYCLES(BUSY_CYCLES)) ctrl_i (
    .clk(clk), .rstN(rstN), .startStb(startStb), .rstartStb(rstartStb),
    .stopStb(stopStb), .addrStb(addrStb), .dataStb(dataStb), .rdReq(rdReq),
    .byteIn(byteIn), .eventHigh(eventHigh), .pending(pending),
    .strb(strb), .ackOut(ackOut), .busy(busy)
  );

  pwgate_dpath dpath_i (
    .clk(clk), .rstN(rstN), .strb(strb), .byteIn(byteIn), .eventHigh(eventHigh),
    .liveCounters(liveCounters), .rdData(rdData), .pending(pending)
  );
endmodule

// File: rtl/pwgate_chk.sv
module pwgate_chk
  import pwgate_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       rstartStb,
  input logic       stopStb,
  input logic       addrStb,
  input logic [7:0] byteIn,
  input logic       eventHigh,
  input logic       ackOut,
  input logic       busy,
  input logic       pending,
  input ctlStrb_t   strb
);
  p_foreign_nack_r2: assert property (@(posedge clk) disable iff (!rstN)
    (addrStb && byteIn != DEV_WR && byteIn != DEV_RD) |=> !ackOut);

  p_commit_on_stop_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |-> stopStb);

  p_rstart_drops_r4: assert property (@(posedge clk) disable iff (!rstN)
    rstartStb |=> !pending);

  p_busy_nack_r5: assert property (@(posedge clk) disable iff (!rstN)
    (addrStb && busy) |=> !ackOut);

  p_busy_from_stop_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(stopStb));

  p_no_buffer_evt_r10: assert property (@(posedge clk) disable iff (!rstN)
    strb.bufWrite |-> !eventHigh);
endmodule

bind pwgate_regwr pwgate_chk chk_i (
  .clk(clk), .rstN(rstN), .rstartStb(rstartStb), .stopStb(stopStb),
  .addrStb(addrStb), .byteIn(byteIn), .eventHigh(eventHigh), .ackOut(ackOut),
  .busy(busy), .pending(pending), .strb(strb)
);

// File: tb/pwgate_regwr_tb_top.sv
module pwgate_regwr_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BUSYC = 16;

  logic clk = 1'b0, rstN = 1'b0;
  logic startStb = 0, rstartStb = 0, stopStb = 0, addrStb = 0, dataStb = 0, rdReq = 0;
  logic [7:0] byteIn = '0;
  logic eventHigh = 1'b0;
  logic [47:0] liveCounters = 48'h665544332211;
  logic ackOut, busy;
  logic [7:0] rdData;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwgate_regwr #(.BUSY_CYCLES(BUSYC)) dut_i (
    .clk(clk), .rstN(rstN), .startStb(startStb), .rstartStb(rstartStb), .stopStb(stopStb),
    .addrStb(addrStb), .dataStb(dataStb), .rdReq(rdReq), .byteIn(byteIn),
    .eventHigh(eventHigh), .liveCounters(liveCounters), .ackOut(ackOut),
    .rdData(rdData), .busy(busy)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doStart();
    @(negedge clk); startStb = 1; @(negedge clk); startStb = 0;
  endtask
  task automatic doRstart();
    @(negedge clk); rstartStb = 1; @(negedge clk); rstartStb = 0;
  endtask
  task automatic doStop();
    @(negedge clk); stopStb = 1; @(negedge clk); stopStb = 0;
  endtask
  task automatic sendAddr(input logic [7:0] b, output logic a);
    @(negedge clk); byteIn = b; addrStb = 1; @(negedge clk); addrStb = 0; a = ackOut;
  endtask
  task automatic sendData(input logic [7:0] b, output logic a);
    @(negedge clk); byteIn = b; dataStb = 1; @(negedge clk); dataStb = 0; a = ackOut;
  endtask
  task automatic readByte(output logic [7:0] d);
    @(negedge clk); rdReq = 1; @(negedge clk); rdReq = 0; d = rdData;
  endtask

  task automatic wrBurst(input logic [7:0] p, input int n, input logic [7:0] d [8]);
    logic a;
    doStart(); sendAddr(8'hD6, a); sendData(p, a);
    for (int i = 0; i < n; i++) sendData(d[i], a);
    doStop();
    repeat (BUSYC + 3) @(negedge clk);
  endtask

  task automatic rdAt(input logic [7:0] p, output logic [7:0] d);
    logic a;
    doStart(); sendAddr(8'hD6, a); sendData(p, a);
    doRstart(); sendAddr(8'hD7, a); readByte(d); doStop();
  endtask

  task automatic t_reset();
    logic [7:0] d; logic a;
    check("R1 busy", {7'b0, busy}, 8'h00);
    doStart(); sendAddr(8'hD7, a); check("R1 ack", {7'b0, a}, 8'h01);
    readByte(d); check("R1 ptr00", d, 8'h00); doStop();
    rdAt(8'h02, d); check("R6 entry", d, 8'h00);
    rdAt(8'h1B, d); check("R6 store", d, 8'h00);
  endtask

  task automatic t_addr();
    logic a; logic [7:0] d;
    doStart(); sendAddr(8'hA0, a); check("R2 foreign nack", {7'b0, a}, 8'h00);
    sendData(8'h14, a); check("R2 data refused", {7'b0, a}, 8'h00);
    sendData(8'h55, a); doStop();
    check("R2 no busy", {7'b0, busy}, 8'h00);
    rdAt(8'h14, d); check("R2 untouched", d, 8'h00);
  endtask

  task automatic t_commit();
    logic a; logic [7:0] d;
    doStart(); sendAddr(8'hD6, a); sendData(8'h10, a); sendData(8'h5A, a);
    doRstart(); doStop();
    rdAt(8'h10, d); check("R4 discard", d, 8'h00);
    wrBurst(8'h10, 1, '{8'h5A, 0, 0, 0, 0, 0, 0, 0});
    rdAt(8'h10, d); check("R4 commit", d, 8'h5A);
  endtask

  task automatic t_wrap();
    logic [7:0] d;
    wrBurst(8'h2E, 3, '{8'h11, 8'h22, 8'h33, 0, 0, 0, 0, 0});
    rdAt(8'h2E, d); check("R3 2E", d, 8'h11);
    rdAt(8'h2F, d); check("R3 2F", d, 8'h22);
    rdAt(8'h28, d); check("R3 wrap 28", d, 8'h33);
  endtask

  task automatic t_busy();
    logic a;
    doStart(); sendAddr(8'hD6, a); sendData(8'h00, a); sendData(8'h01, a); doStop();
    check("R5 busy high", {7'b0, busy}, 8'h01);
    doStart(); sendAddr(8'hD6, a); check("R5 nack busy", {7'b0, a}, 8'h00); doStop();
    repeat (BUSYC + 2) @(negedge clk);
    doStart(); sendAddr(8'hD6, a); check("R5 ack later", {7'b0, a}, 8'h01); doStop();
  endtask

  task automatic t_reserved();
    logic a; logic [7:0] d;
    doStart(); sendAddr(8'hD6, a); sendData(8'h0E, a);
    doRstart(); sendAddr(8'hD7, a);
    readByte(d); check("R9 0E", d, 8'hFF);
    readByte(d); check("R9 0F", d, 8'hFF);
    readByte(d); check("R9 incr 10", d, 8'h5A);
    doStop();
    rdAt(8'h31, d); check("R9 beyond", d, 8'hFF);
  endtask

  task automatic t_snap();
    logic [7:0] d;
    wrBurst(8'h08, 1, '{8'hE1, 0, 0, 0, 0, 0, 0, 0});
    eventHigh = 1;
    rdAt(8'h08, d); check("R11 snap 08", d, 8'h11);
    rdAt(8'h0A, d); check("R11 snap 0A", d, 8'h33);
    eventHigh = 0;
    rdAt(8'h08, d); check("R11 stored 08", d, 8'hE1);
  endtask

  task automatic t_lock();
    logic [7:0] d;
    wrBurst(8'h1A, 2, '{8'h00, 8'h00, 0, 0, 0, 0, 0, 0});
    wrBurst(8'h11, 1, '{8'h77, 0, 0, 0, 0, 0, 0, 0});
    rdAt(8'h11, d); check("R8 partial ignored", d, 8'h77);
    wrBurst(8'h1A, 4, '{8'h12, 8'h34, 8'h56, 8'h78, 0, 0, 0, 0});
    wrBurst(8'h11, 1, '{8'h99, 0, 0, 0, 0, 0, 0, 0});
    rdAt(8'h11, d); check("R7 locked", d, 8'h77);
    rdAt(8'h1A, d); check("R6 store reads 0", d, 8'h00);
    wrBurst(8'h00, 1, '{8'hAB, 0, 0, 0, 0, 0, 0, 0});
    rdAt(8'h00, d); check("R7 open", d, 8'hAB);
    wrBurst(8'h02, 4, '{8'h12, 8'h34, 8'h56, 8'h78, 0, 0, 0, 0});
    wrBurst(8'h11, 1, '{8'h99, 0, 0, 0, 0, 0, 0, 0});
    rdAt(8'h11, d); check("R7 unlocked", d, 8'h99);
  endtask

  task automatic t_event();
    logic a; logic [7:0] d;
    eventHigh = 1;
    doStart(); sendAddr(8'hD6, a); check("R10 addr ack", {7'b0, a}, 8'h01);
    sendData(8'h12, a); sendData(8'hC3, a); check("R10 data nack", {7'b0, a}, 8'h00);
    doStop();
    rdAt(8'h12, d); check("R10 read ok", d, 8'h00);
    eventHigh = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    repeat (2) @(negedge clk);
    t_reset(); t_addr(); t_commit(); t_wrap(); t_busy();
    t_reserved(); t_snap(); t_lock(); t_event();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule